// File: doc/BRIEF.md
# ADC Power Mode Controller

This block decides which parts of a two-channel data converter are powered at any moment and when each channel may again be trusted to produce samples. Two kinds of low-power request come in. A sleep request shuts down everything: both channels, the voltage reference and the clock-multiplying PLL. A nap request is given per channel and powers down only the chosen channels, leaving the reference and PLL running so that recovery is short.

When a request is withdrawn, the block powers the affected circuits back up at once. It then counts sample-clock cycles before it raises the ready flag of each channel. Recovery from nap uses a short count, which can be followed by an optional extra settling count for accurate DC results. Recovery from sleep uses a much longer count. A request that comes back during recovery cancels the count and powers the circuits down again. Sleep always takes precedence over nap. Requests normally come from register bits. In pin-strapped mode a single pin supplies the sleep request, and the register sleep bit and nap mask are ignored.

Top module: `adc_pwr_mode_ctrl`

## Requirements
- R1: After reset every channel is powered (`ch_pd` = 0, `ref_pd` = `pll_pd` = 0) and every `ch_ready` bit is 1.
- R2: A sleep request sampled at a rising edge sets `ref_pd`, `pll_pd` and every `ch_pd` bit to 1 and clears every `ch_ready` bit after that edge.
- R3: The first edge that samples the sleep request low clears `ref_pd`, `pll_pd` and the `ch_pd` bits of channels not napping. The `ch_ready` bits stay 0 until exactly SLEEP_WAKE_CYC edges after that first edge.
- R4: Bit i of the nap mask (bit 0 = channel 0) powers down only channel i: `ch_pd[i]` = 1 and `ch_ready[i]` = 0 after the edge that samples it. `ref_pd`, `pll_pd` and the other channel's outputs are unchanged.
- R5: The first edge that samples nap bit i low clears `ch_pd[i]`. `ch_ready[i]` rises exactly NAP_WAKE_CYC edges after that edge.
- R6: With the settle-extension input at 1, `ch_ready[i]` rises NAP_WAKE_CYC + SETTLE_CYC edges after the nap release.
- R7: Sleep overrides nap. A napping channel is also covered by sleep. When sleep and nap are released on the same edge, readiness returns after SLEEP_WAKE_CYC edges, with no nap count added.
- R8: A request that comes back during recovery (nap during nap recovery, sleep during sleep recovery) sets the power-down outputs again after the sampling edge. A later release restarts the full count.
- R9: With `strap_mode` = 1, the sleep request is `strap_sleep` (1 = sleep). `reg_sleep` and `reg_nap_mask` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_mode | input | 1 | 1 = take the sleep request from the strap pin |
| strap_sleep | input | 1 | Strap-pin sleep request, 1 = sleep |
| reg_sleep | input | 1 | Register sleep request |
| reg_nap_mask | input | NCH | Register nap request, one bit per channel |
| reg_settle_en | input | 1 | Add the extra settle count after nap recovery |
| ch_pd | output | NCH | Channel power-down enables |
| ref_pd | output | 1 | Reference power-down enable |
| pll_pd | output | 1 | PLL power-down enable |
| ch_ready | output | NCH | Channel ready flags |

## Verification
A corrupted recovery counter or state register appears at the ports as a ready flag that rises one or more cycles early or late. The bench therefore samples `ch_ready` on the last edge before the expected rise and again on the edge of the rise. If the sleep and nap states confuse each other, the reference and PLL enables move during a nap, or a wake-up from sleep picks up an extra nap count. Both errors are visible within one recovery window. A lost abort shows up one edge after the request returns, as a power-down enable that stays low.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;

    typedef enum logic [1:0] {
        GS_RUN   = 2'd0,
        GS_SLEEP = 2'd1,
        GS_WAKE  = 2'd2
    } glob_state_t;

    typedef enum logic [1:0] {
        CS_ON     = 2'd0,
        CS_NAP    = 2'd1,
        CS_WAKE   = 2'd2,
        CS_SETTLE = 2'd3
    } chan_state_t;

    typedef struct packed {
        logic sleep;
        logic settle;
    } glob_req_t;

    // Width needed to count from 0 up to n
    function automatic int unsigned cnt_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    // True when a counter at value cnt finishes a window of lim cycles
    function automatic logic win_done(input logic [31:0] cnt, input logic [31:0] lim);
        return (cnt + 32'd1) >= lim;
    endfunction

endpackage

// File: rtl/adc_pwr_req_sel.sv
module adc_pwr_req_sel #(
    parameter int unsigned NCH = 2
) (
    input  logic           strap_mode,
    input  logic           strap_sleep,
    input  logic           reg_sleep,
    input  logic [NCH-1:0] reg_nap_mask,
    output logic           sleep_req,
    output logic [NCH-1:0] nap_req
);
    always_comb begin
        if (strap_mode) begin
            sleep_req = strap_sleep;
            nap_req   = '0;
        end else begin
            sleep_req = reg_sleep;
            nap_req   = reg_nap_mask;
        end
    end
endmodule

// File: rtl/adc_pwr_sleep_fsm.sv
module adc_pwr_sleep_fsm
    import adc_pwr_pkg::*;
#(
    parameter int unsigned SLEEP_WAKE_CYC = 250000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sleep_req,
    output glob_state_t gstate
);
    localparam int unsigned CW = cnt_bits(SLEEP_WAKE_CYC);

    glob_state_t st, st_nx;
    logic [CW-1:0] cnt, cnt_nx;

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        case (st)
            GS_RUN:   if (sleep_req) st_nx = GS_SLEEP;
            GS_SLEEP: if (!sleep_req) begin
                          st_nx  = GS_WAKE;
                          cnt_nx = '0;
                      end
            GS_WAKE: begin
                if (sleep_req) begin
                    st_nx = GS_SLEEP;
                end else if (win_done(32'(cnt), 32'(SLEEP_WAKE_CYC))) begin
                    st_nx  = GS_RUN;
                    cnt_nx = '0;
                end else begin
                    cnt_nx = cnt + CW'(1);
                end
            end
            default: st_nx = GS_SLEEP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= GS_RUN;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    assign gstate = st;
endmodule

// File: rtl/adc_pwr_chan_fsm.sv
module adc_pwr_chan_fsm
    import adc_pwr_pkg::*;
#(
    parameter int unsigned NAP_WAKE_CYC = 100,
    parameter int unsigned SETTLE_CYC   = 6250
) (
    input  logic clk,
    input  logic rst,
    input  logic nap_req,
    input  logic settle_en,
    input  logic sleep_hold,
    output logic napping,
    output logic chan_on
);
    localparam int unsigned MAXC = (NAP_WAKE_CYC > SETTLE_CYC) ? NAP_WAKE_CYC : SETTLE_CYC;
    localparam int unsigned CW   = cnt_bits(MAXC);

    chan_state_t st, st_nx;
    logic [CW-1:0] cnt, cnt_nx;

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        if (sleep_hold) begin
            // Sleep owns the channel; recovery is covered by the sleep count
            st_nx  = nap_req ? CS_NAP : CS_ON;
            cnt_nx = '0;
        end else begin
            case (st)
                CS_ON:  if (nap_req) st_nx = CS_NAP;
                CS_NAP: if (!nap_req) begin
                            st_nx  = CS_WAKE;
                            cnt_nx = '0;
                        end
                CS_WAKE: begin
                    if (nap_req) begin
                        st_nx = CS_NAP;
                    end else if (win_done(32'(cnt), 32'(NAP_WAKE_CYC))) begin
                        st_nx  = settle_en ? CS_SETTLE : CS_ON;
                        cnt_nx = '0;
                    end else begin
                        cnt_nx = cnt + CW'(1);
                    end
                end
                CS_SETTLE: begin
                    if (nap_req) begin
                        st_nx = CS_NAP;
                    end else if (win_done(32'(cnt), 32'(SETTLE_CYC))) begin
                        st_nx  = CS_ON;
                        cnt_nx = '0;
                    end else begin
                        cnt_nx = cnt + CW'(1);
                    end
                end
                default: st_nx = CS_NAP;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= CS_ON;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    assign napping = (st == CS_NAP);
    assign chan_on = (st == CS_ON);
endmodule

// File: rtl/adc_pwr_mode_ctrl.sv
module adc_pwr_mode_ctrl
    import adc_pwr_pkg::*;
#(
    parameter int unsigned NCH            = 2,
    parameter int unsigned NAP_WAKE_CYC   = 100,
    parameter int unsigned SETTLE_CYC     = 6250,
    parameter int unsigned SLEEP_WAKE_CYC = 250000
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           strap_mode,
    input  logic           strap_sleep,
    input  logic           reg_sleep,
    input  logic [NCH-1:0] reg_nap_mask,
    input  logic           reg_settle_en,
    output logic [NCH-1:0] ch_pd,
    output logic           ref_pd,
    output logic           pll_pd,
    output logic [NCH-1:0] ch_ready
);
    logic           sleep_req;
    logic [NCH-1:0] nap_req;
    glob_state_t    gstate;
    glob_req_t      greq;
    logic [NCH-1:0] napping;
    logic [NCH-1:0] chan_on;
    logic           all_down;
    logic           run;

    adc_pwr_req_sel #(.NCH(NCH)) u_sel (
        .strap_mode   (strap_mode),
        .strap_sleep  (strap_sleep),
        .reg_sleep    (reg_sleep),
        .reg_nap_mask (reg_nap_mask),
        .sleep_req    (sleep_req),
        .nap_req      (nap_req)
    );

    assign greq.sleep  = sleep_req;
    assign greq.settle = reg_settle_en;

    adc_pwr_sleep_fsm #(.SLEEP_WAKE_CYC(SLEEP_WAKE_CYC)) u_sleep (
        .clk       (clk),
        .rst       (rst),
        .sleep_req (greq.sleep),
        .gstate    (gstate)
    );

    assign all_down = (gstate == GS_SLEEP);
    assign run      = (gstate == GS_RUN);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        adc_pwr_chan_fsm #(
            .NAP_WAKE_CYC (NAP_WAKE_CYC),
            .SETTLE_CYC   (SETTLE_CYC)
        ) u_ch (
            .clk        (clk),
            .rst        (rst),
            .nap_req    (nap_req[i]),
            .settle_en  (greq.settle),
            .sleep_hold (!run),
            .napping    (napping[i]),
            .chan_on    (chan_on[i])
        );
        assign ch_pd[i]    = all_down | napping[i];
        assign ch_ready[i] = run & chan_on[i];
    end

    assign ref_pd = all_down;
    assign pll_pd = all_down;
endmodule

// File: rtl/adc_pwr_mode_ctrl_chk.sv
module adc_pwr_mode_ctrl_chk #(
    parameter int unsigned NCH          = 2,
    parameter int unsigned NAP_WAKE_CYC = 100
) (
    input logic           clk,
    input logic           rst,
    input logic           strap_mode,
    input logic           strap_sleep,
    input logic           reg_sleep,
    input logic [NCH-1:0] reg_nap_mask,
    input logic [NCH-1:0] ch_pd,
    input logic           ref_pd,
    input logic           pll_pd,
    input logic [NCH-1:0] ch_ready
);
    logic sleep_in;
    assign sleep_in = strap_mode ? strap_sleep : reg_sleep;

    a_r2_sleep_downs_all: assert property (@(posedge clk) disable iff (rst)
        sleep_in |=> (ref_pd && pll_pd && (&ch_pd) && (ch_ready == '0)));

    a_r2_ref_with_all: assert property (@(posedge clk) disable iff (rst)
        ref_pd |-> (pll_pd && (&ch_pd)));

    a_r3_release_powers_ref: assert property (@(posedge clk) disable iff (rst)
        !sleep_in |=> !ref_pd);

    a_r3_ready_needs_ref: assert property (@(posedge clk) disable iff (rst)
        (|ch_ready) |-> !ref_pd);

    a_r9_strap_pin_rules: assert property (@(posedge clk) disable iff (rst)
        (strap_mode && !strap_sleep) |=> !pll_pd);

    a_r4_ready_excludes_pd: assert property (@(posedge clk) disable iff (rst)
        (ch_ready & ch_pd) == '0);

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        logic [31:0] up_run;
        always_ff @(posedge clk) begin
            if (rst || ch_pd[i])
                up_run <= '0;
            else if (!ch_ready[i] && up_run != 32'hFFFF_FFFF)
                up_run <= up_run + 32'd1;
        end

        a_r4_nap_drops_ready: assert property (@(posedge clk) disable iff (rst)
            (!strap_mode && reg_nap_mask[i]) |=> (ch_pd[i] && !ch_ready[i]));

        a_r5_min_recovery: assert property (@(posedge clk) disable iff (rst)
            $rose(ch_ready[i]) |-> (up_run >= 32'(NAP_WAKE_CYC)));
    end
endmodule

bind adc_pwr_mode_ctrl adc_pwr_mode_ctrl_chk #(
    .NCH          (NCH),
    .NAP_WAKE_CYC (NAP_WAKE_CYC)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .strap_mode   (strap_mode),
    .strap_sleep  (strap_sleep),
    .reg_sleep    (reg_sleep),
    .reg_nap_mask (reg_nap_mask),
    .ch_pd        (ch_pd),
    .ref_pd       (ref_pd),
    .pll_pd       (pll_pd),
    .ch_ready     (ch_ready)
);

// File: tb/tb_adc_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module tb_adc_pwr_mode_ctrl;
    localparam int unsigned NCH   = 2;
    localparam int unsigned NAPC  = 8;
    localparam int unsigned SETC  = 5;
    localparam int unsigned SLPC  = 20;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           strap_mode = 1'b0;
    logic           strap_sleep = 1'b0;
    logic           reg_sleep = 1'b0;
    logic [NCH-1:0] reg_nap_mask = '0;
    logic           reg_settle_en = 1'b0;
    logic [NCH-1:0] ch_pd;
    logic           ref_pd;
    logic           pll_pd;
    logic [NCH-1:0] ch_ready;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    adc_pwr_mode_ctrl #(
        .NCH            (NCH),
        .NAP_WAKE_CYC   (NAPC),
        .SETTLE_CYC     (SETC),
        .SLEEP_WAKE_CYC (SLPC)
    ) dut (
        .clk           (clk),
        .rst           (rst),
        .strap_mode    (strap_mode),
        .strap_sleep   (strap_sleep),
        .reg_sleep     (reg_sleep),
        .reg_nap_mask  (reg_nap_mask),
        .reg_settle_en (reg_settle_en),
        .ch_pd         (ch_pd),
        .ref_pd        (ref_pd),
        .pll_pd        (pll_pd),
        .ch_ready      (ch_ready)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Pass n rising edges, then stop at the following falling edge
    task automatic edges(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1", "ch_pd", 32'(ch_pd), 0);
        check("R1", "ref_pd", 32'(ref_pd), 0);
        check("R1", "pll_pd", 32'(pll_pd), 0);
        check("R1", "ch_ready", 32'(ch_ready), 3);
    endtask

    task automatic t_nap_one;
        reg_nap_mask = 2'b01;
        edges(1);
        check("R4", "ch_pd nap ch0", 32'(ch_pd), 1);
        check("R4", "ch_ready nap ch0", 32'(ch_ready), 2);
        check("R4", "ref_pd during nap", 32'(ref_pd), 0);
        check("R4", "pll_pd during nap", 32'(pll_pd), 0);
        edges(3);
        reg_nap_mask = 2'b00;
        edges(1);
        check("R5", "ch_pd after release", 32'(ch_pd), 0);
        edges(NAPC - 1);
        check("R5", "ready before window end", 32'(ch_ready), 2);
        edges(1);
        check("R5", "ready at window end", 32'(ch_ready), 3);
    endtask

    task automatic t_nap_settle;
        reg_settle_en = 1'b1;
        reg_nap_mask  = 2'b10;
        edges(2);
        check("R4", "ch1 only down", 32'(ch_pd), 2);
        check("R4", "ch0 still ready", 32'(ch_ready), 1);
        reg_nap_mask = 2'b00;
        edges(NAPC + SETC);
        check("R6", "ready before settle end", 32'(ch_ready), 1);
        edges(1);
        check("R6", "ready after settle end", 32'(ch_ready), 3);
        reg_settle_en = 1'b0;
    endtask

    task automatic t_nap_abort;
        reg_nap_mask = 2'b01;
        edges(2);
        reg_nap_mask = 2'b00;
        edges(3);
        check("R8", "ch0 powered in recovery", 32'(ch_pd), 0);
        reg_nap_mask = 2'b01;
        edges(1);
        check("R8", "nap abort re-downs ch0", 32'(ch_pd), 1);
        reg_nap_mask = 2'b00;
        edges(NAPC);
        check("R8", "count restarted, not ready", 32'(ch_ready), 2);
        edges(1);
        check("R8", "ready after full count", 32'(ch_ready), 3);
    endtask

    task automatic t_sleep;
        reg_sleep = 1'b1;
        edges(1);
        check("R2", "ref_pd", 32'(ref_pd), 1);
        check("R2", "pll_pd", 32'(pll_pd), 1);
        check("R2", "ch_pd", 32'(ch_pd), 3);
        check("R2", "ch_ready", 32'(ch_ready), 0);
        edges(4);
        reg_sleep = 1'b0;
        edges(1);
        check("R3", "ref_pd after release", 32'(ref_pd), 0);
        check("R3", "ch_pd after release", 32'(ch_pd), 0);
        edges(SLPC - 1);
        check("R3", "ready before sleep window", 32'(ch_ready), 0);
        edges(1);
        check("R3", "ready at sleep window", 32'(ch_ready), 3);
    endtask

    task automatic t_sleep_abort;
        reg_sleep = 1'b1;
        edges(2);
        reg_sleep = 1'b0;
        edges(6);
        check("R8", "ref up in sleep recovery", 32'(ref_pd), 0);
        reg_sleep = 1'b1;
        edges(1);
        check("R8", "sleep abort re-downs ref", 32'(ref_pd), 1);
        reg_sleep = 1'b0;
        edges(SLPC);
        check("R8", "sleep count restarted", 32'(ch_ready), 0);
        edges(1);
        check("R8", "ready after full sleep count", 32'(ch_ready), 3);
    endtask

    task automatic t_sleep_over_nap;
        reg_nap_mask = 2'b01;
        edges(2);
        reg_sleep = 1'b1;
        edges(1);
        check("R7", "ref_pd while napping", 32'(ref_pd), 1);
        check("R7", "all ch_pd", 32'(ch_pd), 3);
        edges(3);
        reg_sleep    = 1'b0;
        reg_nap_mask = 2'b00;
        edges(SLPC);
        check("R7", "not ready before sleep window", 32'(ch_ready), 0);
        edges(1);
        check("R7", "ready with no nap count added", 32'(ch_ready), 3);
    endtask

    task automatic t_strap;
        strap_mode   = 1'b1;
        reg_sleep    = 1'b1;
        reg_nap_mask = 2'b11;
        edges(2);
        check("R9", "reg sleep ignored", 32'(ref_pd), 0);
        check("R9", "nap mask ignored", 32'(ch_ready), 3);
        strap_sleep = 1'b1;
        edges(1);
        check("R9", "pin sleep", 32'(ref_pd), 1);
        strap_sleep = 1'b0;
        edges(SLPC + 1);
        check("R9", "pin release recovery", 32'(ch_ready), 3);
        strap_mode   = 1'b0;
        reg_sleep    = 1'b0;
        reg_nap_mask = 2'b00;
        edges(1);
    endtask

    initial begin
        edges(3);
        rst = 1'b0;
        edges(1);
        t_reset();
        t_nap_one();
        t_nap_settle();
        t_nap_abort();
        t_sleep();
        t_sleep_abort();
        t_sleep_over_nap();
        t_strap();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule